// File: doc/BRIEF.md
# Reduced-Bin Streaming Histogram Generator

This block builds an intensity histogram from a stream of grayscale pixels. Pixels enter one per cycle, in raster order, over a valid/ready interface, and a marker flags the final pixel of a frame. A start pulse sets the resolution for the coming frame. In the full setting every intensity has its own bin. In the two reduced settings low-order pixel bits are dropped, so neighbouring intensities share a bin and the bin store shrinks to a half or a quarter.

A frame runs in three phases. First every bin of the chosen resolution is cleared, one bin per cycle. Then pixels are accumulated. Each pixel does a two-stage read-modify-write of its bin, and a pixel that hits the bin still being written takes the freshly incremented value instead of the stale stored one. After the final pixel the bins are streamed out in ascending order, one entry per cycle, each with its index and count. The block then waits for the next start pulse.

Top module: `hist_gen`

## Requirements
- R1: While reset is asserted and after its release until a start pulse, `pix_ready_o` and `rd_valid_o` are low.
- R2: A start pulse sampled while idle clears the active bins, one per cycle. `pix_ready_o` stays low for exactly as many cycles as the mode has bins (256, 128 or 64) and then goes high.
- R3: Mode code 0 (full) counts each pixel in bin `pixel[7:0]`, and readout has 256 entries.
- R4: Mode code 1 (half) counts each pixel in bin `pixel[7:1]`, and readout has 128 entries.
- R5: Mode code 2 (quarter) counts each pixel in bin `pixel[7:2]`, and readout has 64 entries.
- R6: Pixels hitting the same bin on consecutive cycles, or with idle cycles between them, are all counted.
- R7: A bin count stops at 2^CNT_W-1 and never wraps.
- R8: After the final pixel, readout presents `rd_valid_o` on consecutive cycles with `rd_index_o` counting up from 0. `rd_count_o` is the count of that bin, `rd_last_o` is high only on the final entry, and `pix_ready_o` is low during readout.
- R9: The mode is taken only at the start pulse. Changing `mode_i` during a frame does not change that frame's binning or readout length.
- R10: Mode code 3 behaves as full resolution.
- R11: Counts from an earlier frame do not carry into a later frame.
- R12: A start pulse while the block is accumulating is ignored. The frame continues, and its counts are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begins a frame (clear phase) when idle |
| mode_i | input | 2 | Resolution: 0 full, 1 half, 2 quarter, 3 full |
| pix_valid_i | input | 1 | Pixel present |
| pix_data_i | input | PIX_W | Pixel intensity |
| pix_last_i | input | 1 | Marks the final pixel of the frame |
| pix_ready_o | output | 1 | High while pixels are accepted |
| rd_valid_o | output | 1 | Readout entry present |
| rd_index_o | output | PIX_W | Bin index of the readout entry |
| rd_count_o | output | CNT_W | Count of that bin |
| rd_last_o | output | 1 | Final readout entry |

## Verification
The assertions check on every cycle that back-to-back writes to one bin step by exactly one or hold at saturation, and that a written count never wraps to zero. They also check that clearing never overlaps an update, that readout indices climb without gaps while input is refused, and that the latched mode holds for the whole frame. Only the bench scenarios can show the count values themselves: the bin mapping in each mode, the clear-phase length, the separation between frames, and that a start pulse or a mode change in mid-frame leaves the result untouched.

// File: rtl/hist_pkg.sv
// Shared types for the histogram generator.
package hist_pkg;
    typedef enum logic [1:0] {
        HM_FULL     = 2'd0,
        HM_HALF     = 2'd1,
        HM_QUARTER  = 2'd2,
        HM_FULL_ALT = 2'd3
    } hist_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_ACCUM,
        ST_DRAIN,
        ST_READ
    } hist_state_e;

    // Number of low pixel bits dropped for a given mode.
    function automatic int unsigned mode_shift(hist_mode_e m);
        case (m)
            HM_HALF:    return 1;
            HM_QUARTER: return 2;
            default:    return 0;
        endcase
    endfunction
endpackage

// File: rtl/hist_bin_map.sv
// Maps a pixel to its bin index for the latched mode.
// Assumes PIX_W > 2 so the quarter mode still leaves index bits.
module hist_bin_map
    import hist_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  hist_mode_e       mode,
    input  logic [PIX_W-1:0] pix,
    output logic [PIX_W-1:0] bin,
    output logic [PIX_W-1:0] last_bin
);
    // Drop the low bits that the mode merges; the highest index shrinks to match.
    always_comb begin
        bin      = pix >> mode_shift(mode);
        last_bin = {PIX_W{1'b1}} >> mode_shift(mode);
    end
endmodule

// File: rtl/hist_ctrl.sv
// Frame sequencer: idle, clear, accumulate, drain, readout.
// Assumes the bin store updates one cycle after an accepted pixel,
// so a single drain cycle makes the last update visible before readout.
module hist_ctrl
    import hist_pkg::*;
#(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             pix_valid_i,
    input  logic             pix_last_i,
    input  logic [PIX_W-1:0] last_bin,
    output hist_mode_e       mode_q,
    output logic             pix_ready_o,
    output logic             clr_en,
    output logic             rd_en,
    output logic [PIX_W-1:0] seq_addr,
    output logic             rd_valid_o,
    output logic [PIX_W-1:0] rd_index_o,
    output logic             rd_last_o
);
    hist_state_e      state;
    logic [PIX_W-1:0] cnt;

    // Phase decode for the datapath.
    always_comb begin
        pix_ready_o = (state == ST_ACCUM);
        clr_en      = (state == ST_CLEAR);
        rd_en       = (state == ST_READ);
        seq_addr    = cnt;
    end

    // State, sweep counter, latched mode and readout tags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            mode_q     <= HM_FULL;
            rd_valid_o <= 1'b0;
            rd_index_o <= '0;
            rd_last_o  <= 1'b0;
        end else begin
            rd_valid_o <= 1'b0;
            rd_last_o  <= 1'b0;
            case (state)
                ST_IDLE: if (start_i) begin
                    mode_q <= hist_mode_e'(mode_i);
                    cnt    <= '0;
                    state  <= ST_CLEAR;
                end
                ST_CLEAR: begin
                    if (cnt == last_bin) begin
                        cnt   <= '0;
                        state <= ST_ACCUM;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ACCUM: if (pix_valid_i && pix_last_i) state <= ST_DRAIN;
                ST_DRAIN: begin
                    cnt   <= '0;
                    state <= ST_READ;
                end
                ST_READ: begin
                    rd_valid_o <= 1'b1;
                    rd_index_o <= cnt;
                    rd_last_o  <= (cnt == last_bin);
                    if (cnt == last_bin) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(mode_q));
endmodule

// File: rtl/hist_rmw.sv
// Bin store with a two-stage read-modify-write and same-bin forwarding.
// Stage 1 captures the address and the stored count. Stage 2 writes the
// saturating increment and keeps it so that the next update can reuse it.
// Assumes clear and accumulate never overlap (the sequencer guarantees it).
module hist_rmw #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_en,
    input  logic             acc_en,
    input  logic [PIX_W-1:0] acc_addr,
    input  logic             rd_en,
    input  logic [PIX_W-1:0] seq_addr,
    output logic [CNT_W-1:0] rd_data
);
    localparam int         NBINS   = 1 << PIX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] mem [NBINS];
    logic             s1_v, s2_v;
    logic [PIX_W-1:0] s1_addr, s2_addr;
    logic [CNT_W-1:0] s1_rd, s2_val;
    logic [CNT_W-1:0] opnd, upd;

    // Pick the in-flight value when the previous update hit the same bin.
    always_comb begin
        opnd = (s2_v && s2_addr == s1_addr) ? s2_val : s1_rd;
        upd  = (opnd == CNT_MAX) ? CNT_MAX : opnd + 1'b1;
    end

    // Single write port: clear sweep or update write-back.
    always_ff @(posedge clk) begin
        if (clr_en)
            mem[seq_addr] <= '0;
        else if (s1_v)
            mem[s1_addr] <= upd;
    end

    // Read ports: operand fetch for updates and readout data.
    always_ff @(posedge clk) begin
        if (acc_en) s1_rd <= mem[acc_addr];
        if (rd_en)  rd_data <= mem[seq_addr];
    end

    // Pipeline control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_addr <= '0;
            s2_v    <= 1'b0;
            s2_addr <= '0;
            s2_val  <= '0;
        end else begin
            s1_v    <= acc_en;
            s1_addr <= acc_addr;
            s2_v    <= s1_v;
            s2_addr <= s1_addr;
            s2_val  <= upd;
        end
    end

    // R6
    fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_v && $past(s2_v) && s2_addr == $past(s2_addr))
        |-> (s2_val == $past(s2_val) + 1'b1 || s2_val == CNT_MAX));
    // R7
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_v |-> s2_val != '0);
    // R2
    clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> (!acc_en && !s1_v));
endmodule

// File: rtl/hist_gen.sv
// Top of the histogram generator: sequencer, bin mapping and bin store.
// Assumes pixels are presented only while pix_ready_o is high.
module hist_gen
    import hist_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic             pix_valid_i,
    input  logic [PIX_W-1:0] pix_data_i,
    input  logic             pix_last_i,
    output logic             pix_ready_o,
    output logic             rd_valid_o,
    output logic [PIX_W-1:0] rd_index_o,
    output logic [CNT_W-1:0] rd_count_o,
    output logic             rd_last_o
);
    hist_mode_e       mode_q;
    logic [PIX_W-1:0] bin, last_bin, seq_addr;
    logic             clr_en, rd_en, acc_en;

    assign acc_en = pix_valid_i && pix_ready_o;

    hist_bin_map #(.PIX_W(PIX_W)) u_map (
        .mode     (mode_q),
        .pix      (pix_data_i),
        .bin      (bin),
        .last_bin (last_bin)
    );

    hist_ctrl #(.PIX_W(PIX_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .pix_valid_i (pix_valid_i),
        .pix_last_i  (pix_last_i),
        .last_bin    (last_bin),
        .mode_q      (mode_q),
        .pix_ready_o (pix_ready_o),
        .clr_en      (clr_en),
        .rd_en       (rd_en),
        .seq_addr    (seq_addr),
        .rd_valid_o  (rd_valid_o),
        .rd_index_o  (rd_index_o),
        .rd_last_o   (rd_last_o)
    );

    hist_rmw #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_rmw (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_en   (clr_en),
        .acc_en   (acc_en),
        .acc_addr (bin),
        .rd_en    (rd_en),
        .seq_addr (seq_addr),
        .rd_data  (rd_count_o)
    );

    // R8
    rd_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_o && $past(rd_valid_o)) |-> rd_index_o == $past(rd_index_o) + 1'b1);
    // R8
    rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> !pix_ready_o);
endmodule

// File: tb/hist_gen_tb.sv
module hist_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W = 8;
    localparam int CNT_W = 5;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic pix_valid_i = 1'b0;
    logic [PIX_W-1:0] pix_data_i = '0;
    logic pix_last_i = 1'b0;
    logic pix_ready_o, rd_valid_o, rd_last_o;
    logic [PIX_W-1:0] rd_index_o;
    logic [CNT_W-1:0] rd_count_o;

    int n_tests = 0;
    int n_fail = 0;
    int refh [256];
    logic [7:0] pbuf [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    hist_gen #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .pix_valid_i(pix_valid_i), .pix_data_i(pix_data_i), .pix_last_i(pix_last_i),
        .pix_ready_o(pix_ready_o), .rd_valid_o(rd_valid_o), .rd_index_o(rd_index_o),
        .rd_count_o(rd_count_o), .rd_last_o(rd_last_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nbins(input logic [1:0] m);
        return (m == 2'd1) ? 128 : (m == 2'd2) ? 64 : 256;
    endfunction

    function automatic int binof(input logic [1:0] m, input logic [7:0] p);
        return (m == 2'd1) ? int'(p >> 1) : (m == 2'd2) ? int'(p >> 2) : int'(p);
    endfunction

    // Runs one frame: start, clear-length check, pixel drive, readout compare.
    task automatic run_frame(input logic [1:0] m, input int n, input bit gap,
                             input logic [1:0] mid_mode, input bit poke, input string req);
        int nb = nbins(m);
        int c = 0;
        int w = 0;
        for (int b = 0; b < 256; b++) refh[b] = 0;
        for (int i = 0; i < n; i++) begin
            int b = binof(m, pbuf[i]);
            if (refh[b] < CMAX) refh[b]++;
        end
        @(negedge clk); start_i = 1'b1; mode_i = m;
        @(negedge clk); start_i = 1'b0;
        while (!pix_ready_o && c < 400) begin c++; @(negedge clk); end
        chk(c == nb, "R2 clear length", c, nb);
        for (int i = 0; i < n; i++) begin
            if (i == n/2) mode_i = mid_mode;
            if (poke && i == n/2) start_i = 1'b1;
            pix_valid_i = 1'b1; pix_data_i = pbuf[i]; pix_last_i = (i == n-1);
            @(negedge clk);
            start_i = 1'b0;
            if (poke && i == n/2) chk(pix_ready_o == 1'b1, "R12 start ignored, ready", pix_ready_o, 1);
            if (gap && i != n-1) begin pix_valid_i = 1'b0; @(negedge clk); end
        end
        pix_valid_i = 1'b0; pix_last_i = 1'b0;
        while (!rd_valid_o && w < 50) begin w++; @(negedge clk); end
        chk(rd_valid_o == 1'b1, {req, " readout start (R8)"}, rd_valid_o, 1);
        for (int k = 0; k < nb; k++) begin
            if (!rd_valid_o || rd_index_o != k[PIX_W-1:0] || rd_last_o != (k == nb-1) || pix_ready_o)
                chk(1'b0, {req, " R8 readout framing idx"}, int'(rd_index_o), k);
            chk(int'(rd_count_o) == refh[k], {req, " bin count"}, int'(rd_count_o), refh[k]);
            @(negedge clk);
        end
        chk(rd_valid_o == 1'b0, "R8 readout length", rd_valid_o, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!pix_ready_o && !rd_valid_o, "R1 in reset", int'(pix_ready_o) + int'(rd_valid_o), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!pix_ready_o && !rd_valid_o, "R1 idle after reset", int'(pix_ready_o) + int'(rd_valid_o), 0);
    endtask

    task automatic t_full_ramp();   // R3
        for (int i = 0; i < 256; i++) pbuf[i] = 8'(i);
        run_frame(2'd0, 256, 1'b0, 2'd0, 1'b0, "R3 full ramp");
    endtask

    task automatic t_half_ramp();   // R4
        for (int i = 0; i < 256; i++) pbuf[i] = 8'(255 - i);
        run_frame(2'd1, 256, 1'b0, 2'd1, 1'b0, "R4 half ramp");
    endtask

    task automatic t_quarter_lfsr(); // R5
        logic [7:0] x = 8'h5A;
        for (int i = 0; i < 300; i++) begin
            pbuf[i] = x;
            x = {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]};
        end
        run_frame(2'd2, 300, 1'b0, 2'd2, 1'b0, "R5 quarter lfsr");
    endtask

    task automatic t_same_bin();    // R6 back-to-back merged intensities
        for (int i = 0; i < 20; i++) pbuf[i] = (i % 2 == 0) ? 8'd10 : 8'd11;
        run_frame(2'd1, 20, 1'b0, 2'd1, 1'b0, "R6 same bin back-to-back");
        for (int i = 0; i < 9; i++) pbuf[i] = 8'd200;
        run_frame(2'd0, 9, 1'b1, 2'd0, 1'b0, "R6 same bin with gaps");
    endtask

    task automatic t_saturate();    // R7
        for (int i = 0; i < 40; i++) pbuf[i] = 8'd77;
        run_frame(2'd0, 40, 1'b0, 2'd0, 1'b0, "R7 saturation");
    endtask

    task automatic t_mid_mode();    // R9
        for (int i = 0; i < 64; i++) pbuf[i] = 8'(i * 4 + 1);
        run_frame(2'd2, 64, 1'b0, 2'd0, 1'b0, "R9 mid-frame mode change");
    endtask

    task automatic t_alt_code();    // R10
        for (int i = 0; i < 30; i++) pbuf[i] = 8'(i * 7);
        run_frame(2'd3, 30, 1'b0, 2'd3, 1'b0, "R10 code 3 full");
    endtask

    task automatic t_fresh_frame(); // R11
        for (int i = 0; i < 12; i++) pbuf[i] = 8'd33;
        run_frame(2'd0, 12, 1'b0, 2'd0, 1'b0, "R11 first frame");
        for (int i = 0; i < 5; i++) pbuf[i] = 8'd33;
        run_frame(2'd0, 5, 1'b0, 2'd0, 1'b0, "R11 second frame");
    endtask

    task automatic t_start_poke();  // R12
        for (int i = 0; i < 16; i++) pbuf[i] = 8'(i + 100);
        run_frame(2'd0, 16, 1'b0, 2'd0, 1'b1, "R12 start in frame");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_full_ramp();
        t_half_ramp();
        t_quarter_lfsr();
        t_same_bin();
        t_saturate();
        t_mid_mode();
        t_alt_code();
        t_fresh_frame();
        t_start_poke();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule